// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block sits on the memory side of a single-data-rate SDRAM interface. On every rising clock edge it samples chip select, the three command strobes, the two bank-select bits and the thirteen address bits. It turns them into one registered command code with a strobe, and it presents the bank, row or opcode, and column that belong to that command. It also resolves whether a precharge targets one bank or all four, and it flags auto-precharge on reads and writes.

Alongside the decode it keeps per-bank state: whether a row is open, which row was activated, and whether a burst is still running. That state lets a single low sample of clock enable be classified as precharge power-down (nothing open), active power-down (a row open, no burst) or clock suspend (a burst in flight). It also lets an auto-precharge burst close its bank by itself when the burst ends. Timing limits, refresh counting, the data path and the array are handled elsewhere.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: Inputs are sampled only at the rising clock edge, and every output is registered. The result of the inputs sampled at edge N is visible from just after edge N until edge N+1.
- R2: When chip select (`cs_n_i`) is sampled high, the command is treated as no operation. `cmd_o` reads 0, `cmd_stb_o` stays low, and no bank state changes.
- R3: With chip select low and clock enable high, {ras_n,cas_n,we_n} decodes as follows: 011 is ACTIVATE (`cmd_o`=1), 101 is READ (2), 100 is WRITE (3), 010 is PRECHARGE (4), 000 is MODE SET (5) and 001 is REFRESH (6). Both 111 and the unlisted code 110 give NOP (0). `cmd_stb_o` is high for every code except NOP.
- R4: ACTIVATE to an idle bank marks it open and stores A12..A0 as that bank's row in `open_rows_o[13*b +: 13]`. ACTIVATE to a bank that is already open leaves its open flag and stored row unchanged. `row_o` and `bank_o` still report the command.
- R5: READ and WRITE set `bank_o` from BA, `col_o` from A8..A0 and `auto_pre_o` from A10. A READ or WRITE to an idle bank changes no bank state.
- R6: PRECHARGE with A10 high drives `pre_mask_o`=4'b1111 and closes all banks, whatever BA holds. With A10 low it drives a one-hot mask at bit BA and closes only that bank. `pre_mask_o` is 0 in every cycle that does not report a PRECHARGE.
- R7: A READ or WRITE to an open bank marks it busy for BURST_LEN (4) edges that have clock enable high, and a new access restarts that count. If A10 was high on the last access, the bank closes at the edge where the count ends; otherwise it stays open. A PRECHARGE ends the count at once.
- R8: While clock enable is sampled low, no command is decoded, `cmd_stb_o` stays low, bank open flags, rows and burst counts are held, and the presented command is ignored.
- R9: At each edge with clock enable low, `pwr_state_o` becomes 3 (suspend) if any bank is busy, otherwise 2 (active power-down) if any bank is open, otherwise 1 (precharge power-down). At each edge with clock enable high it becomes 0 (running).
- R10: MODE SET reports the mode-register selector BA on `bank_o` and the opcode A12..A0 on `row_o`.
- R11: A synchronous active-low reset clears all open flags, rows and burst counts, sets `pwr_state_o` to 0 and `cmd_stb_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select / mode-register select |
| a_i | input | 13 | Address and opcode bus |
| cmd_o | output | 3 | Decoded command code |
| cmd_stb_o | output | 1 | High for one cycle per decoded non-NOP command |
| bank_o | output | 2 | Bank (or mode register) of the last command |
| row_o | output | 13 | Row of the last ACTIVATE or opcode of the last MODE SET |
| col_o | output | 9 | Column of the last READ or WRITE |
| auto_pre_o | output | 1 | Auto-precharge flag of the last READ or WRITE |
| pre_mask_o | output | 4 | Banks closed by the PRECHARGE reported this cycle |
| bank_open_o | output | 4 | Per-bank open flag |
| bank_busy_o | output | 4 | Per-bank burst-in-progress flag |
| open_rows_o | output | 52 | Stored row per bank, bank b at bits 13*b+12..13*b |
| pwr_state_o | output | 2 | 0 running, 1 precharge power-down, 2 active power-down, 3 suspend |

## Verification
Every decoded field, the precharge mask, the open and busy flags and the power state are due one clock after the edge that sampled the stimulus. The bench therefore drives each vector at a falling edge and checks at the next falling edge, half a period after the registering edge. The auto-precharge close is due on the fourth clock-enabled edge after the access, so the bench counts clock-enabled NOPs and checks just before and just after that edge. Edges with clock enable low are left out of that count, which makes the suspend case show up as a shifted close.

// File: rtl/sdcd_pkg.sv
// Package: shared command and power-state codes for the SDRAM command
// decoder. Assumes three-bit command and two-bit power encodings are
// visible on the ports of the top module.
package sdcd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_MRS = 3'd5,
        CMD_REF = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN     = 2'd0,
        PWR_PRE_PD  = 2'd1,
        PWR_ACT_PD  = 2'd2,
        PWR_SUSPEND = 2'd3
    } pwr_e;

endpackage

// File: rtl/sdcd_cmd_decode.sv
// Module: combinational command decoder. Turns the sampled strobes into a
// command code. Assumes its inputs are the pin values present at the
// coming rising edge; clock enable low or chip select high yields NOP.
module sdcd_cmd_decode
    import sdcd_pkg::*;
(
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    logic [2:0] code;

    assign code = {ras_n_i, cas_n_i, we_n_i};

    // Map the strobe pattern onto a command, masking by CKE and CS.
    always_comb begin
        cmd_o = CMD_NOP;
        if (cke_i && !cs_n_i) begin
            case (code)
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b000:  cmd_o = CMD_MRS;
                3'b001:  cmd_o = CMD_REF;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcd_bank_slot.sv
// Module: state of a single bank: open flag, stored row, burst counter and
// pending auto-precharge. Assumes adv_i is clock enable; with it low every
// register holds. Precharge outranks any other command on this bank.
module sdcd_bank_slot
    import sdcd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4,
    localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  cmd_e             cmd_i,
    input  logic             sel_i,
    input  logic             pre_hit_i,
    input  logic             ap_req_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic             busy_o,
    output logic [ROW_W-1:0] row_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             ap_q;
    logic             access;

    assign access = sel_i && ((cmd_i == CMD_RD) || (cmd_i == CMD_WR));

    // Advance open flag, row, burst count and auto-precharge on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
            cnt_q  <= '0;
            ap_q   <= 1'b0;
        end else if (adv_i) begin
            if (pre_hit_i && (cmd_i == CMD_PRE)) begin
                open_o <= 1'b0;
                cnt_q  <= '0;
                ap_q   <= 1'b0;
            end else if (sel_i && (cmd_i == CMD_ACT) && !open_o) begin
                open_o <= 1'b1;
                row_o  <= row_i;
            end else if (access && open_o) begin
                cnt_q <= CNT_LOAD;
                ap_q  <= ap_req_i;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if ((cnt_q == CNT_W'(1)) && ap_q) begin
                    open_o <= 1'b0;
                    ap_q   <= 1'b0;
                end
            end
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sdcd_bank_tracker.sv
// Module: array of bank slots plus the precharge target resolver. Assumes
// the address bit at AP_BIT selects all banks on a precharge; otherwise the
// bank-select field picks exactly one.
module sdcd_bank_tracker
    import sdcd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    input  cmd_e                       cmd_i,
    input  logic [BA_W-1:0]            ba_i,
    input  logic [ROW_W-1:0]           a_i,
    output logic [NUM_BANKS-1:0]       open_o,
    output logic [NUM_BANKS-1:0]       busy_o,
    output logic [NUM_BANKS*ROW_W-1:0] rows_o,
    output logic [NUM_BANKS-1:0]       pre_mask_o
);

    logic [NUM_BANKS-1:0] sel;

    // Resolve the one-hot bank select and the precharge target set.
    always_comb begin
        sel = '0;
        sel[ba_i] = 1'b1;
        pre_mask_o = a_i[AP_BIT] ? {NUM_BANKS{1'b1}} : sel;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdcd_bank_slot #(
            .ROW_W     (ROW_W),
            .BURST_LEN (BURST_LEN)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv_i     (adv_i),
            .cmd_i     (cmd_i),
            .sel_i     (sel[b]),
            .pre_hit_i (pre_mask_o[b]),
            .ap_req_i  (a_i[AP_BIT]),
            .row_i     (a_i),
            .open_o    (open_o[b]),
            .busy_o    (busy_o[b]),
            .row_o     (rows_o[b*ROW_W +: ROW_W])
        );
    end

endmodule

// File: rtl/sdcd_power_class.sv
// Module: power-state classifier. On an edge with clock enable low it picks
// suspend, active power-down or precharge power-down from the bank state
// held before that edge; clock enable high returns it to running.
module sdcd_power_class
    import sdcd_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke_i,
    input  logic [NUM_BANKS-1:0] open_i,
    input  logic [NUM_BANKS-1:0] busy_i,
    output pwr_e                 pwr_o
);

    // Register the classified power state each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_o <= PWR_RUN;
        end else if (cke_i) begin
            pwr_o <= PWR_RUN;
        end else if (|busy_i) begin
            pwr_o <= PWR_SUSPEND;
        end else if (|open_i) begin
            pwr_o <= PWR_ACT_PD;
        end else begin
            pwr_o <= PWR_PRE_PD;
        end
    end

endmodule

// File: rtl/sdram_cmd_decoder.sv
// Module: top of the SDRAM command decoder. Samples control and address
// pins at each rising edge, registers the decoded command with its fields,
// and exposes per-bank state and the power classification. Assumes timing
// rules are enforced elsewhere; it decodes whatever it is given.
module sdram_cmd_decoder
    import sdcd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke_i,
    input  logic                  cs_n_i,
    input  logic                  ras_n_i,
    input  logic                  cas_n_i,
    input  logic                  we_n_i,
    input  logic [1:0]            ba_i,
    input  logic [12:0]           a_i,
    output logic [2:0]            cmd_o,
    output logic                  cmd_stb_o,
    output logic [1:0]            bank_o,
    output logic [12:0]           row_o,
    output logic [8:0]            col_o,
    output logic                  auto_pre_o,
    output logic [3:0]            pre_mask_o,
    output logic [3:0]            bank_open_o,
    output logic [3:0]            bank_busy_o,
    output logic [51:0]           open_rows_o,
    output logic [1:0]            pwr_state_o
);

    localparam int BA_W = $clog2(NUM_BANKS);

    cmd_e                 dec_cmd;
    logic [NUM_BANKS-1:0] pre_mask_c;
    pwr_e                 pwr_q;

    sdcd_cmd_decode u_dec (
        .cke_i   (cke_i),
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cmd_o   (dec_cmd)
    );

    sdcd_bank_tracker #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .AP_BIT    (AP_BIT),
        .BURST_LEN (BURST_LEN)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (cke_i),
        .cmd_i      (dec_cmd),
        .ba_i       (ba_i[BA_W-1:0]),
        .a_i        (a_i[ROW_W-1:0]),
        .open_o     (bank_open_o),
        .busy_o     (bank_busy_o),
        .rows_o     (open_rows_o),
        .pre_mask_o (pre_mask_c)
    );

    sdcd_power_class #(
        .NUM_BANKS (NUM_BANKS)
    ) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke_i  (cke_i),
        .open_i (bank_open_o),
        .busy_i (bank_busy_o),
        .pwr_o  (pwr_q)
    );

    assign pwr_state_o = pwr_q;

    // Register the decoded command and the fields that belong to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o      <= CMD_NOP;
            cmd_stb_o  <= 1'b0;
            bank_o     <= '0;
            row_o      <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            pre_mask_o <= '0;
        end else begin
            cmd_o      <= dec_cmd;
            cmd_stb_o  <= (dec_cmd != CMD_NOP);
            pre_mask_o <= (dec_cmd == CMD_PRE) ? pre_mask_c : '0;
            if (dec_cmd != CMD_NOP) begin
                bank_o <= ba_i;
            end
            if ((dec_cmd == CMD_ACT) || (dec_cmd == CMD_MRS)) begin
                row_o <= a_i;
            end
            if ((dec_cmd == CMD_RD) || (dec_cmd == CMD_WR)) begin
                col_o      <= a_i[COL_W-1:0];
                auto_pre_o <= a_i[AP_BIT];
            end
        end
    end

endmodule

// File: rtl/sdcd_checker.sv
// Module: property checker for the SDRAM command decoder, bound to the top.
// Assumes rst_n is low at time zero; every property waits one enabled edge.
module sdcd_checker
    import sdcd_pkg::*;
#(
    parameter int AP_BIT = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cke_i,
    input logic        cs_n_i,
    input logic [12:0] a_i,
    input logic [2:0]  cmd_o,
    input logic        cmd_stb_o,
    input logic [3:0]  pre_mask_o,
    input logic [3:0]  bank_open_o,
    input logic [3:0]  bank_busy_o,
    input logic [51:0] open_rows_o,
    input logic [1:0]  pwr_state_o
);

    logic past_ok;

    // Mark that at least one edge out of reset has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_cs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cs_n_i) |-> !cmd_stb_o);

    p_cke_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(cke_i) |->
            (!cmd_stb_o && $stable(bank_open_o) && $stable(open_rows_o)));

    p_pre_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o && (cmd_o == CMD_PRE) |->
            ((pre_mask_o != 4'b0) && ((bank_open_o & pre_mask_o) == 4'b0)));

    p_pre_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && cmd_stb_o && (cmd_o == CMD_PRE) && !$past(a_i[AP_BIT]) |->
            ($countones(pre_mask_o) == 1));

    p_busy_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_busy_o & ~bank_open_o) == 4'b0);

    p_prepd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o == PWR_PRE_PD |-> bank_open_o == 4'b0);

    p_actpd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o == PWR_ACT_PD |-> (bank_open_o != 4'b0) && (bank_busy_o == 4'b0));

    p_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o == PWR_SUSPEND |-> bank_busy_o != 4'b0);

    p_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cke_i) |-> pwr_state_o == PWR_RUN);

endmodule

bind sdram_cmd_decoder sdcd_checker #(
    .AP_BIT (AP_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_i       (cke_i),
    .cs_n_i      (cs_n_i),
    .a_i         (a_i),
    .cmd_o       (cmd_o),
    .cmd_stb_o   (cmd_stb_o),
    .pre_mask_o  (pre_mask_o),
    .bank_open_o (bank_open_o),
    .bank_busy_o (bank_busy_o),
    .open_rows_o (open_rows_o),
    .pwr_state_o (pwr_state_o)
);

// File: tb/tb_sdram_cmd_decoder.sv
// Bench: vector table walked by one loop, then directed corner tests.
module tb_sdram_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_i = 1'b1;
    logic        cs_n_i = 1'b1;
    logic        ras_n_i = 1'b1;
    logic        cas_n_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic [1:0]  ba_i = '0;
    logic [12:0] a_i = '0;
    logic [2:0]  cmd_o;
    logic        cmd_stb_o;
    logic [1:0]  bank_o;
    logic [12:0] row_o;
    logic [8:0]  col_o;
    logic        auto_pre_o;
    logic [3:0]  pre_mask_o;
    logic [3:0]  bank_open_o;
    logic [3:0]  bank_busy_o;
    logic [51:0] open_rows_o;
    logic [1:0]  pwr_state_o;

    int n_checks = 0;
    int n_errs = 0;

    sdram_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .ba_i(ba_i), .a_i(a_i), .cmd_o(cmd_o), .cmd_stb_o(cmd_stb_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .auto_pre_o(auto_pre_o), .pre_mask_o(pre_mask_o),
        .bank_open_o(bank_open_o), .bank_busy_o(bank_busy_o),
        .open_rows_o(open_rows_o), .pwr_state_o(pwr_state_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {cke, cs_n, ras/cas/we, ba, a, exp cmd, exp stb, exp open, exp pwr}
    localparam logic [29:0] VEC [NV] = '{
        {1'b1,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b0000,2'd0}, // R3 NOP
        {1'b1,1'b1,3'b011,2'd0,13'h0000, 3'd0,1'b0,4'b0000,2'd0}, // R2 masked ACT
        {1'b0,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b0000,2'd1}, // R9 pre pd
        {1'b0,1'b0,3'b011,2'd2,13'h0000, 3'd0,1'b0,4'b0000,2'd1}, // R8 ignored
        {1'b1,1'b0,3'b011,2'd1,13'h0ABC, 3'd1,1'b1,4'b0010,2'd0}, // R4
        {1'b1,1'b0,3'b011,2'd3,13'h1FFF, 3'd1,1'b1,4'b1010,2'd0}, // R4
        {1'b0,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1010,2'd2}, // R9 act pd
        {1'b1,1'b0,3'b101,2'd1,13'h0405, 3'd2,1'b1,4'b1010,2'd0}, // R7 RD ap
        {1'b0,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1010,2'd3}, // R9 suspend
        {1'b0,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1010,2'd3}, // R8 frozen
        {1'b1,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1010,2'd0},
        {1'b1,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1010,2'd0},
        {1'b1,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1010,2'd0},
        {1'b1,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1000,2'd0}, // R7 closes
        {1'b0,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b1000,2'd2},
        {1'b1,1'b0,3'b010,2'd3,13'h0000, 3'd4,1'b1,4'b0000,2'd0}, // R6 single
        {1'b0,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b0000,2'd1},
        {1'b1,1'b0,3'b000,2'd2,13'h0033, 3'd5,1'b1,4'b0000,2'd0}, // R3 MRS
        {1'b1,1'b0,3'b001,2'd0,13'h0000, 3'd6,1'b1,4'b0000,2'd0}, // R3 REF
        {1'b1,1'b0,3'b011,2'd0,13'h0111, 3'd1,1'b1,4'b0001,2'd0},
        {1'b1,1'b0,3'b011,2'd2,13'h0222, 3'd1,1'b1,4'b0101,2'd0},
        {1'b1,1'b0,3'b010,2'd1,13'h0400, 3'd4,1'b1,4'b0000,2'd0}, // R6 all
        {1'b1,1'b0,3'b100,2'd0,13'h0400, 3'd3,1'b1,4'b0000,2'd0}, // R5 WR idle
        {1'b0,1'b0,3'b111,2'd0,13'h0000, 3'd0,1'b0,4'b0000,2'd1}, // R5 no busy
        {1'b1,1'b0,3'b110,2'd0,13'h0000, 3'd0,1'b0,4'b0000,2'd0}, // R3 unlisted
        {1'b1,1'b1,3'b010,2'd0,13'h0400, 3'd0,1'b0,4'b0000,2'd0}  // R2 masked
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one pin vector at a falling edge, return at the next falling edge.
    task automatic step(input logic cke, input logic cs, input logic [2:0] rcw,
                        input logic [1:0] ba, input logic [12:0] a);
        cke_i = cke; cs_n_i = cs;
        {ras_n_i, cas_n_i, we_n_i} = rcw;
        ba_i = ba; a_i = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();
        step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0000);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL R1 watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        check("R11", "stb", cmd_stb_o, 0);
        check("R11", "open", bank_open_o, 0);
        check("R11", "busy", bank_busy_o, 0);
        check("R11", "pwr", pwr_state_o, 0);
        check("R11", "rows", open_rows_o, 0);
        rst_n = 1'b1;

        // R1: table, each result checked one edge after it was sampled
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][29], VEC[i][28], VEC[i][27:25], VEC[i][24:23], VEC[i][22:10]);
            check("R1/R3 table", $sformatf("cmd v%0d", i), cmd_o, VEC[i][9:7]);
            check("R2/R3 table", $sformatf("stb v%0d", i), cmd_stb_o, VEC[i][6]);
            check("R4/R6/R7 table", $sformatf("open v%0d", i), bank_open_o, VEC[i][5:2]);
            check("R9 table", $sformatf("pwr v%0d", i), pwr_state_o, VEC[i][1:0]);
        end

        // R4: activate latches row; second activate to open bank ignored
        step(1'b1, 1'b0, 3'b011, 2'd2, 13'h1234);
        check("R4", "row stored", open_rows_o[26 +: 13], 13'h1234);
        check("R4", "bank_o", bank_o, 2);
        step(1'b1, 1'b0, 3'b011, 2'd2, 13'h0055);
        check("R4", "row kept", open_rows_o[26 +: 13], 13'h1234);
        check("R4", "row_o reports", row_o, 13'h0055);
        check("R4", "still open", bank_open_o, 4'b0100);

        // R5/R7: read without auto-precharge keeps the bank open
        step(1'b1, 1'b0, 3'b101, 2'd2, 13'h01A7);
        check("R5", "col", col_o, 9'h1A7);
        check("R5", "ap", auto_pre_o, 0);
        check("R7", "busy", bank_busy_o, 4'b0100);
        repeat (4) nop();
        check("R7", "busy done", bank_busy_o, 0);
        check("R7", "no-ap open", bank_open_o, 4'b0100);

        // R5/R7: write with auto-precharge closes on the fourth enabled edge
        step(1'b1, 1'b0, 3'b100, 2'd2, 13'h05FF);
        check("R5", "col wr", col_o, 9'h1FF);
        check("R5", "ap wr", auto_pre_o, 1);
        repeat (3) nop();
        check("R7", "open before end", bank_open_o, 4'b0100);
        nop();
        check("R7", "closed at end", bank_open_o, 4'b0000);

        // R6: precharge masks
        step(1'b1, 1'b0, 3'b011, 2'd0, 13'h0010);
        step(1'b1, 1'b0, 3'b011, 2'd3, 13'h0020);
        step(1'b1, 1'b0, 3'b010, 2'd0, 13'h0000);
        check("R6", "single mask", pre_mask_o, 4'b0001);
        check("R6", "single close", bank_open_o, 4'b1000);
        nop();
        check("R6", "mask cleared", pre_mask_o, 4'b0000);
        step(1'b1, 1'b0, 3'b010, 2'd2, 13'h0400);
        check("R6", "all mask", pre_mask_o, 4'b1111);
        check("R6", "all close", bank_open_o, 4'b0000);

        // R7: precharge during a burst ends it; R9 then precharge power-down
        step(1'b1, 1'b0, 3'b011, 2'd1, 13'h0001);
        step(1'b1, 1'b0, 3'b101, 2'd1, 13'h0400);
        check("R7", "busy set", bank_busy_o, 4'b0010);
        step(1'b1, 1'b0, 3'b010, 2'd1, 13'h0000);
        check("R7", "pre clears busy", bank_busy_o, 4'b0000);
        step(1'b0, 1'b0, 3'b111, 2'd0, 13'h0000);
        check("R9", "pre pd", pwr_state_o, 1);

        // R7: a new access restarts the count and drops auto-precharge
        step(1'b1, 1'b0, 3'b011, 2'd0, 13'h0001);
        step(1'b1, 1'b0, 3'b101, 2'd0, 13'h0400);
        nop(); nop();
        step(1'b1, 1'b0, 3'b101, 2'd0, 13'h0003);
        repeat (3) nop();
        check("R7", "restart busy", bank_busy_o, 4'b0001);
        repeat (2) nop();
        check("R7", "restart kept open", bank_open_o, 4'b0001);
        check("R4", "row bank0", open_rows_o[0 +: 13], 13'h0001);

        // R10: mode set reports selector and opcode
        step(1'b1, 1'b0, 3'b000, 2'd2, 13'h0021);
        check("R10", "cmd", cmd_o, 5);
        check("R10", "selector", bank_o, 2);
        check("R10", "opcode", row_o, 13'h0021);

        // R9 then R11: active power-down, reset mid-state
        step(1'b0, 1'b0, 3'b111, 2'd0, 13'h0000);
        check("R9", "act pd", pwr_state_o, 2);
        rst_n = 1'b0;
        nop();
        check("R11", "open after reset", bank_open_o, 0);
        check("R11", "rows after reset", open_rows_o, 0);
        check("R11", "pwr after reset", pwr_state_o, 0);
        check("R11", "stb after reset", cmd_stb_o, 0);
        rst_n = 1'b1;
        nop();

        summary();
        $finish;
    end

endmodule